// File: doc/BRIEF.md
# Post-Load Startup Sequencer

This block takes a device from "configuration data loaded" to "running user logic". A single start strobe launches a walk through eight numbered phases (0 to 7), one phase per clock unless a hold condition applies. Four release events are tied to phases by 3-bit settings: switching off the global I/O tristate, releasing the open-drain DONE line, raising the global write enable that lets flip-flops and memories change state, and raising the end-of-startup flag. An event takes effect in the phase its setting names, and several events may share a phase.

The walk can be held in a chosen phase until a clock-manager lock input is high, or until an impedance-calibration match input is high. Each hold has its own enable. It is also held in the DONE phase until the sensed DONE line reads high, because other devices on the wired line may still pull it low. The usual setting puts the events in phases 4, 5, 6 and 7 in the order tristate off, DONE, write enable, end of startup, with both holds off. Once an event has taken effect, its output keeps that value until reset or a reconfiguration request.

Top module: `startup_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, `gts_o` is 1 and `done_rel_o`, `gwe_o` and `eos_o` are 0, and the sequencer is idle.
- R2: When `start_i` is high at an idle edge, phase 0 is current for the following cycle. With no hold active, each later edge advances the phase by one. An edge in phase 7 without a hold ends the walk.
- R3: An event whose phase setting equals the current phase takes effect at the edge that ends that cycle: `gts_o` falls, or `done_rel_o`, `gwe_o` or `eos_o` rises. Events that share a phase take effect at the same edge.
- R4: With `lock_wait_en_i` = 1, the walk stays in phase `lock_phase_i` while `lock_i` is 0. With `lock_wait_en_i` = 0, `lock_i` has no effect.
- R5: With `match_wait_en_i` = 1, the walk stays in phase `match_phase_i` while `match_i` is 0. With `match_wait_en_i` = 0, `match_i` has no effect.
- R6: The walk leaves the phase named by `ph_done_i` only at an edge where `done_sense_i` is 1. The DONE event is therefore followed by at least one extra cycle in that phase.
- R7: Once an event has taken effect, its output holds that value until reset or `restart_i`.
- R8: `restart_i` high at an edge returns all outputs to the values given in R1 and the sequencer to idle. The walk can then be started again.
- R9: `start_i` has no effect while a walk is in progress or after it has ended; only `restart_i` or reset makes the sequencer startable again.
- R10: Phase settings are decoded as unsigned 3-bit phase numbers 0 to 7. They must be held stable while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the walk from idle |
| restart_i | input | 1 | Reconfiguration request; clears everything to idle |
| lock_i | input | 1 | Clock-manager lock indication |
| match_i | input | 1 | Impedance-calibration match indication |
| lock_wait_en_i | input | 1 | Enable hold on lock |
| match_wait_en_i | input | 1 | Enable hold on match |
| lock_phase_i | input | 3 | Phase that holds for lock |
| match_phase_i | input | 3 | Phase that holds for match |
| ph_gts_i | input | 3 | Phase of tristate-off event |
| ph_done_i | input | 3 | Phase of DONE release event |
| ph_gwe_i | input | 3 | Phase of write-enable event |
| ph_eos_i | input | 3 | Phase of end-of-startup event |
| done_sense_i | input | 1 | Sensed level of the wired DONE line |
| gts_o | output | 1 | Global tristate, 1 holds I/O off |
| done_rel_o | output | 1 | 1 releases the open-drain DONE line |
| gwe_o | output | 1 | Global write enable |
| eos_o | output | 1 | End of startup |

## Verification
The assertions check on every cycle the local rules: the reset and restart values, the one-phase step when no hold applies, that the phase stays put under a lock, match or DONE hold, that each event takes effect in its own phase, and that released outputs never fall back. Only the bench's scenarios can show whole-walk behaviour. These cover the exact edge at which end of startup appears with the usual settings, a long DONE hold-off from a neighbour, all events placed in one phase, holds whose condition is already met, ignored start pulses during and after a walk, and a second walk after a restart. A behavioural model checks these against the ports on every clock.

// File: rtl/startup_pkg.sv
// Package: shared constants for the startup sequencer.
// Assumes a phase number fits in PHASE_W bits and that there are four events.
package startup_pkg;
    localparam int PHASE_W    = 3;
    localparam int NUM_EVENTS = 4;

    // Event slots, in the packed order used by the top module
    localparam int EV_GTS  = 0;
    localparam int EV_DONE = 1;
    localparam int EV_GWE  = 2;
    localparam int EV_EOS  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/startup_phase_ctr.sv
// Phase walker: idle -> phases 0..2^PHASE_W-1 -> finished.
// Assumes stall_i is already qualified with the current phase.
// clear_i has priority over everything except reset.
module startup_phase_ctr
    import startup_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          start_i,
    input  logic          stall_i,
    output logic [PW-1:0] phase_o,
    output logic          running_o
);
    localparam logic [PW-1:0] LAST_PH = {PW{1'b1}};

    seq_state_e state_q;

    // Advance the walk one phase per cycle unless held
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            state_q <= ST_IDLE;
            phase_o <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        phase_o <= '0;
                    end
                end
                ST_RUN: begin
                    if (!stall_i) begin
                        if (phase_o == LAST_PH) state_q <= ST_FIN;
                        else                    phase_o <= phase_o + 1'b1;
                    end
                end
                default: state_q <= ST_FIN;
            endcase
        end
    end

    assign running_o = (state_q == ST_RUN);

    // Unheld phase steps by exactly one
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !stall_i && !clear_i && phase_o != LAST_PH)
        |=> (running_o && phase_o == $past(phase_o) + 1'b1));

    // Start from idle enters phase 0
    assert_start_phase0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !clear_i) |=> (running_o && phase_o == '0));

    // Finished state is left only by clear
    assert_fin_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN && !clear_i) |=> (state_q == ST_FIN));
endmodule

// File: rtl/startup_stall.sv
// Hold evaluation: decides whether the current phase must repeat.
// Pure combinational; the caller gates it with the running state.
// Assumes phase settings are stable during a walk.
module startup_stall
    import startup_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic [PW-1:0] phase_i,
    input  logic          lock_en_i,
    input  logic [PW-1:0] lock_ph_i,
    input  logic          lock_i,
    input  logic          match_en_i,
    input  logic [PW-1:0] match_ph_i,
    input  logic          match_i,
    input  logic [PW-1:0] done_ph_i,
    input  logic          done_sense_i,
    output logic          stall_o
);
    logic hold_lock, hold_match, hold_done;

    // Each hold source is active only in its own phase
    always_comb begin
        hold_lock  = lock_en_i  && (phase_i == lock_ph_i)  && !lock_i;
        hold_match = match_en_i && (phase_i == match_ph_i) && !match_i;
        hold_done  = (phase_i == done_ph_i) && !done_sense_i;
        stall_o    = hold_lock || hold_match || hold_done;
    end
endmodule

// File: rtl/startup_event_flag.sv
// Sticky event output: takes its active value when fired, keeps it until
// reset or clear. IDLE_VAL selects the inactive level (1 for tristate).
module startup_event_flag #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic fire_i,
    output logic q_o
);
    // Latch the active level on the first fire
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) q_o <= IDLE_VAL;
        else if (fire_i)       q_o <= ~IDLE_VAL;
    end

    // Once active, the output never returns without clear
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o != IDLE_VAL && !clear_i) |=> (q_o != IDLE_VAL));
endmodule

// File: rtl/startup_seq.sv
// Top of the post-load startup sequencer. Walks eight phases after start,
// fires the four release events in their programmed phases, and holds on
// lock, match or the sensed DONE line. Assumes done_sense_i reflects the
// wired DONE level, which includes this block's own release.
module startup_seq
    import startup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       restart_i,
    input  logic       lock_i,
    input  logic       match_i,
    input  logic       lock_wait_en_i,
    input  logic       match_wait_en_i,
    input  logic [2:0] lock_phase_i,
    input  logic [2:0] match_phase_i,
    input  logic [2:0] ph_gts_i,
    input  logic [2:0] ph_done_i,
    input  logic [2:0] ph_gwe_i,
    input  logic [2:0] ph_eos_i,
    input  logic       done_sense_i,
    output logic       gts_o,
    output logic       done_rel_o,
    output logic       gwe_o,
    output logic       eos_o
);
    logic [PHASE_W-1:0]    phase;
    logic                  running;
    logic                  stall;
    logic [PHASE_W-1:0]    ev_ph   [NUM_EVENTS];
    logic [NUM_EVENTS-1:0] ev_fire;
    logic [NUM_EVENTS-1:0] ev_q;

    // Gather event phase settings into slot order
    always_comb begin
        ev_ph[EV_GTS]  = ph_gts_i;
        ev_ph[EV_DONE] = ph_done_i;
        ev_ph[EV_GWE]  = ph_gwe_i;
        ev_ph[EV_EOS]  = ph_eos_i;
    end

    startup_stall #(.PW(PHASE_W)) u_stall (
        .phase_i      (phase),
        .lock_en_i    (lock_wait_en_i),
        .lock_ph_i    (lock_phase_i),
        .lock_i       (lock_i),
        .match_en_i   (match_wait_en_i),
        .match_ph_i   (match_phase_i),
        .match_i      (match_i),
        .done_ph_i    (ph_done_i),
        .done_sense_i (done_sense_i),
        .stall_o      (stall)
    );

    startup_phase_ctr #(.PW(PHASE_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (restart_i),
        .start_i   (start_i),
        .stall_i   (stall),
        .phase_o   (phase),
        .running_o (running)
    );

    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_ev
        // Event fires whenever the walk sits in its phase
        assign ev_fire[e] = running && (phase == ev_ph[e]);
        startup_event_flag #(.IDLE_VAL(e == EV_GTS)) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (restart_i),
            .fire_i  (ev_fire[e]),
            .q_o     (ev_q[e])
        );
    end

    assign gts_o      = ev_q[EV_GTS];
    assign done_rel_o = ev_q[EV_DONE];
    assign gwe_o      = ev_q[EV_GWE];
    assign eos_o      = ev_q[EV_EOS];

    // Reset values
    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (gts_o && !done_rel_o && !gwe_o && !eos_o));

    // Restart values
    assert_restart_vals_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (gts_o && !done_rel_o && !gwe_o && !eos_o));

    // Write enable appears after its phase
    assert_gwe_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase == ph_gwe_i && !restart_i) |=> gwe_o);

    // Tristate drops after its phase
    assert_gts_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase == ph_gts_i && !restart_i) |=> !gts_o);

    // Lock hold keeps the phase
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && lock_wait_en_i && phase == lock_phase_i && !lock_i && !restart_i)
        |=> (running && phase == $past(phase)));

    // Match hold keeps the phase
    assert_match_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && match_wait_en_i && phase == match_phase_i && !match_i && !restart_i)
        |=> (running && phase == $past(phase)));

    // DONE phase is not left while the line reads low
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase == ph_done_i && !done_sense_i && !restart_i)
        |=> (running && phase == $past(phase) && done_rel_o));
endmodule

// File: tb/startup_seq_bench.sv
module startup_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, restart_i = 0, lock_i = 0, match_i = 0;
    logic lock_wait_en_i = 0, match_wait_en_i = 0;
    logic [2:0] lock_phase_i = 0, match_phase_i = 0;
    logic [2:0] ph_gts_i = 3'd4, ph_done_i = 3'd5, ph_gwe_i = 3'd6, ph_eos_i = 3'd7;
    logic hold_low = 0;
    logic done_sense_i;
    logic gts_o, done_rel_o, gwe_o, eos_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Reference model state
    int m_state = 0;   // 0 idle, 1 running, 2 finished
    int m_phase = 0;
    bit m_gts = 1, m_done = 0, m_gwe = 0, m_eos = 0;

    always #4 clk = ~clk;

    assign done_sense_i = done_rel_o & ~hold_low;

    startup_seq u_startup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
        .lock_i(lock_i), .match_i(match_i),
        .lock_wait_en_i(lock_wait_en_i), .match_wait_en_i(match_wait_en_i),
        .lock_phase_i(lock_phase_i), .match_phase_i(match_phase_i),
        .ph_gts_i(ph_gts_i), .ph_done_i(ph_done_i), .ph_gwe_i(ph_gwe_i),
        .ph_eos_i(ph_eos_i), .done_sense_i(done_sense_i),
        .gts_o(gts_o), .done_rel_o(done_rel_o), .gwe_o(gwe_o), .eos_o(eos_o)
    );

    // Behavioural model of the walk, updated on every rising edge
    always @(posedge clk) begin
        bit sense, hold;
        sense = m_done && !hold_low;
        if (!rst_n || restart_i) begin
            m_state = 0; m_phase = 0;
            m_gts = 1; m_done = 0; m_gwe = 0; m_eos = 0;
        end else if (m_state == 0) begin
            if (start_i) begin m_state = 1; m_phase = 0; end
        end else if (m_state == 1) begin
            if (int'(ph_gts_i)  == m_phase) m_gts  = 0;
            if (int'(ph_done_i) == m_phase) m_done = 1;
            if (int'(ph_gwe_i)  == m_phase) m_gwe  = 1;
            if (int'(ph_eos_i)  == m_phase) m_eos  = 1;
            hold = (lock_wait_en_i && int'(lock_phase_i) == m_phase && !lock_i)
                || (match_wait_en_i && int'(match_phase_i) == m_phase && !match_i)
                || (int'(ph_done_i) == m_phase && !sense);
            if (!hold) begin
                if (m_phase == 7) m_state = 2;
                else m_phase = m_phase + 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs against the model away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(cur_req, "gts",  int'(gts_o),      int'(m_gts));
            check(cur_req, "done", int'(done_rel_o), int'(m_done));
            check(cur_req, "gwe",  int'(gwe_o),      int'(m_gwe));
            check(cur_req, "eos",  int'(eos_o),      int'(m_eos));
        end
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic do_restart();
        @(negedge clk); restart_i = 1;
        @(negedge clk); restart_i = 0;
    endtask

    task automatic outs_are(string req, int g, int d, int w, int e);
        check(req, "gts",  int'(gts_o), g);
        check(req, "done", int'(done_rel_o), d);
        check(req, "gwe",  int'(gwe_o), w);
        check(req, "eos",  int'(eos_o), e);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        outs_are("R1", 1, 0, 0, 0);
        rst_n = 1;
        idle(2);
        outs_are("R1", 1, 0, 0, 0);

        // R2 R3 R6: usual order 4,5,6,7; end of startup seen at the 10th negedge after start edge
        cur_req = "R2";
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;   // negedge 1 after the start edge
        idle(8);                       // negedge 9
        check("R2", "eos before last edge", int'(eos_o), 0);
        check("R3", "gwe at negedge 9", int'(gwe_o), 1);
        idle(1);                       // negedge 10
        check("R2", "eos at negedge 10", int'(eos_o), 1);
        outs_are("R3", 0, 1, 1, 1);

        // R9: start after finish has no effect; R7: outputs hold
        cur_req = "R9";
        pulse_start();
        idle(5);
        outs_are("R7", 0, 1, 1, 1);

        // R8: restart clears
        cur_req = "R8";
        do_restart();
        outs_are("R8", 1, 0, 0, 0);

        // R6 R10: all events in phase 2, neighbour holds DONE low
        cur_req = "R6";
        ph_gts_i = 3'd2; ph_done_i = 3'd2; ph_gwe_i = 3'd2; ph_eos_i = 3'd2;
        hold_low = 1;
        pulse_start();
        idle(6);
        outs_are("R10", 0, 1, 1, 1);
        hold_low = 0;
        idle(8);
        do_restart();
        outs_are("R8", 1, 0, 0, 0);

        // R4: lock hold in phase 1, events back to usual order
        cur_req = "R4";
        ph_gts_i = 3'd4; ph_done_i = 3'd5; ph_gwe_i = 3'd6; ph_eos_i = 3'd7;
        lock_wait_en_i = 1; lock_phase_i = 3'd1; lock_i = 0;
        pulse_start();
        idle(10);
        check("R4", "gts held while waiting", int'(gts_o), 1);
        // R9: start mid-walk ignored
        pulse_start();
        lock_i = 1;
        idle(12);
        outs_are("R4", 0, 1, 1, 1);
        do_restart();

        // R5: match hold in phase 3
        cur_req = "R5";
        lock_wait_en_i = 0; lock_i = 0;
        match_wait_en_i = 1; match_phase_i = 3'd3; match_i = 0;
        pulse_start();
        idle(9);
        check("R5", "gts held while waiting", int'(gts_o), 1);
        match_i = 1;
        idle(10);
        outs_are("R5", 0, 1, 1, 1);
        do_restart();

        // R4 R5: holds disabled with inputs low, or enabled with inputs high
        cur_req = "R4";
        match_wait_en_i = 0; match_i = 0; lock_i = 0;
        pulse_start();
        idle(9);
        check("R4", "lock ignored when disabled", int'(eos_o), 1);
        do_restart();
        cur_req = "R5";
        lock_wait_en_i = 1; match_wait_en_i = 1; lock_i = 1; match_i = 1;
        pulse_start();
        idle(9);
        check("R5", "no hold when met", int'(eos_o), 1);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule